// File: doc/BRIEF.md
# CAN Controller Control Register with Timestamp Counter

This block holds the 16-bit control word of a CAN controller and the free-running timestamp counter that the word governs. Software writes the word through a single-register port and reads it back at any time. The static fields drive three levels to the protocol engine: module reset, loopback and BasicCAN mode. A two-bit field picks the timestamp prescaler, which divides the incoming bit-clock tick by 1, 2, 3 or 4 before the 16-bit counter advances.

Two command bits can only be set by software and clear themselves once the hardware has acted. The timestamp-clear command is handled by a two-state machine, TS_RUN and TS_CLR. A write that sets the command moves it from TS_RUN to TS_CLR. In TS_CLR the counter is zeroed on the next edge and the machine returns to TS_RUN, unless a new set arrives in that cycle, in which case it stays in TS_CLR.

The error-counter-clear command is handled by a three-state machine, EC_IDLE, EC_PULSE and EC_WAIT. A set in EC_IDLE moves it to EC_PULSE, where a one-cycle clear pulse goes to the error counters. From EC_PULSE it goes to EC_IDLE if the acknowledge is high and to EC_WAIT otherwise. From EC_WAIT it goes to EC_IDLE when the acknowledge is high. The readback bit is 1 in every state except EC_IDLE.

Top module: `can_ctl_ts`

## Requirements
- R1: After reset, rd_data reads 16'h0011 (bit0 and bit4 set), can_reset is 1, loopback_en, basic_en and ec_clr_pulse are 0, and ts_value is 0.
- R2: A write stores bit0 (reset A), bit1 (loopback), bit3 (BasicCAN), bit4 (reset B) and bits 9:8 (prescaler select), and rd_data returns them in the same positions from the next cycle on. Bits 2, 7:5 and 15:12 always read 0, whatever was written to them.
- R3: can_reset is 1 whenever stored bit0 or bit4 is 1, including when the two differ. loopback_en follows bit1 and basic_en follows bit3.
- R4: With prescaler select s (00, 01, 10 or 11), ts_value advances by one on every (s+1)-th bit_tick and holds otherwise. A tick is counted in the cycle bit_tick is high, and the new value is visible after that edge.
- R5: ts_value wraps from 16'hFFFF to 16'h0000.
- R6: Writing 1 to bit10 sets the bit. On the following edge ts_value becomes 0 and bit10 reads 0 again. In that cycle the clear takes priority over any increment.
- R7: Writing 0 to bit10 or bit11 has no effect; only the hardware returns them to 0.
- R8: Writing 1 to bit11 while it reads 0 raises ec_clr_pulse for exactly the next cycle. Bit11 then reads 1 until the first edge at which ec_clr_ack is high, counted from the pulse cycle, and reads 0 after that edge. An acknowledge while bit11 is 0 is ignored.
- R9: A write that changes the prescaler select, and a timestamp clear, both restart the divide phase. A bit_tick in that same cycle is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Current control word readback |
| bit_tick | input | 1 | One-cycle CAN bit-clock tick |
| ec_clr_ack | input | 1 | Error counters have been cleared |
| can_reset | output | 1 | Holds the protocol engine in reset |
| loopback_en | output | 1 | Loopback mode enable |
| basic_en | output | 1 | BasicCAN mode enable |
| ec_clr_pulse | output | 1 | One-cycle request to clear the error counters |
| ts_value | output | 16 | Running timestamp counter |

## Verification
Two pairs of functions can meet in one cycle. The first is a timestamp clear and a prescaled increment. The bench keeps bit_tick high with a divide of 1 while setting bit10, so the clear edge coincides with a due increment; it is judged by ts_value reading 0, not 1. The second is a prescaler change and a tick. The bench writes a new select while bit_tick is high and expects the tick to be dropped and the phase to restart. A behavioural model run beside the design checks every output on every cycle, including the acknowledge arriving in the pulse cycle itself.

// File: rtl/can_ctl_pkg.sv
package can_ctl_pkg;
    localparam int REG_W    = 16;
    localparam int B_RSTA   = 0;
    localparam int B_LOOP   = 1;
    localparam int B_BASIC  = 3;
    localparam int B_RSTB   = 4;
    localparam int B_PS_LO  = 8;
    localparam int B_TSCLR  = 10;
    localparam int B_ECCLR  = 11;

    typedef enum logic [1:0] {
        EC_IDLE  = 2'd0,
        EC_PULSE = 2'd1,
        EC_WAIT  = 2'd2
    } ec_state_t;

    typedef enum logic {
        TS_RUN = 1'b0,
        TS_CLR = 1'b1
    } ts_state_t;
endpackage

// File: rtl/can_ecr_fsm.sv
module can_ecr_fsm
    import can_ctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic ack,
    output logic pulse,
    output logic busy
);
    ec_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= EC_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EC_IDLE:  if (set_req) state_d = EC_PULSE;
            EC_PULSE: state_d = ack ? EC_IDLE : EC_WAIT;
            EC_WAIT:  if (ack) state_d = EC_IDLE;
            default:  state_d = EC_IDLE;
        endcase
    end

    always_comb begin
        pulse = (state_q == EC_PULSE);
        busy  = (state_q != EC_IDLE);
    end

    p_pulse_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);
    p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ack) |=> busy);
endmodule

// File: rtl/can_ts_presc.sv
module can_ts_presc #(
    parameter int PS_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic [PS_W-1:0] sel,
    input  logic            restart,
    output logic            adv
);
    logic [PS_W-1:0] phase_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            phase_q <= '0;
        else if (restart)
            phase_q <= '0;
        else if (tick)
            phase_q <= (phase_q == sel) ? '0 : phase_q + PS_W'(1);
    end

    always_comb adv = tick && !restart && (phase_q == sel);

    p_phase_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q <= sel);
endmodule

// File: rtl/can_ts_cnt.sv
module can_ts_cnt
    import can_ctl_pkg::*;
#(
    parameter int TS_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            set_req,
    input  logic            adv,
    output logic [TS_W-1:0] value,
    output logic            busy
);
    ts_state_t       state_q, state_d;
    logic [TS_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TS_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TS_RUN:  if (set_req) state_d = TS_CLR;
            TS_CLR:  state_d = set_req ? TS_CLR : TS_RUN;
            default: state_d = TS_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                cnt_q <= '0;
        else if (state_q == TS_CLR) cnt_q <= '0;
        else if (adv)              cnt_q <= cnt_q + TS_W'(1);
    end

    always_comb begin
        value = cnt_q;
        busy  = (state_q == TS_CLR);
    end

    p_ts_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (value == '0));
    p_ts_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> (value == $past(value) || value == $past(value) + TS_W'(1)));
endmodule

// File: rtl/can_ctl_ts.sv
module can_ctl_ts
    import can_ctl_pkg::*;
#(
    parameter int TS_W = 16,
    parameter int PS_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             bit_tick,
    input  logic             ec_clr_ack,
    output logic             can_reset,
    output logic             loopback_en,
    output logic             basic_en,
    output logic             ec_clr_pulse,
    output logic [TS_W-1:0]  ts_value
);
    logic            rsta_q, rstb_q, loop_q, basic_q;
    logic [PS_W-1:0] sel_q;
    logic [PS_W-1:0] sel_wr;
    logic            sel_chg, ts_busy, ec_busy, adv;

    always_comb begin
        sel_wr  = wr_data[B_PS_LO +: PS_W];
        sel_chg = wr_en && (sel_wr != sel_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsta_q  <= 1'b1;
            rstb_q  <= 1'b1;
            loop_q  <= 1'b0;
            basic_q <= 1'b0;
            sel_q   <= '0;
        end else if (wr_en) begin
            rsta_q  <= wr_data[B_RSTA];
            rstb_q  <= wr_data[B_RSTB];
            loop_q  <= wr_data[B_LOOP];
            basic_q <= wr_data[B_BASIC];
            sel_q   <= sel_wr;
        end
    end

    can_ts_presc #(.PS_W(PS_W)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (bit_tick),
        .sel     (sel_q),
        .restart (sel_chg || ts_busy),
        .adv     (adv)
    );

    can_ts_cnt #(.TS_W(TS_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_req (wr_en && wr_data[B_TSCLR]),
        .adv     (adv),
        .value   (ts_value),
        .busy    (ts_busy)
    );

    can_ecr_fsm u_ecr (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_req (wr_en && wr_data[B_ECCLR]),
        .ack     (ec_clr_ack),
        .pulse   (ec_clr_pulse),
        .busy    (ec_busy)
    );

    always_comb begin
        rd_data                   = '0;
        rd_data[B_RSTA]           = rsta_q;
        rd_data[B_LOOP]           = loop_q;
        rd_data[B_BASIC]          = basic_q;
        rd_data[B_RSTB]           = rstb_q;
        rd_data[B_PS_LO +: PS_W]  = sel_q;
        rd_data[B_TSCLR]          = ts_busy;
        rd_data[B_ECCLR]          = ec_busy;
        can_reset                 = rsta_q || rstb_q;
        loopback_en               = loop_q;
        basic_en                  = basic_q;
    end

    p_ec_bit_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[B_ECCLR] && !ec_clr_ack) |=> rd_data[B_ECCLR]);
    p_ec_pulse_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_data[B_ECCLR] && wr_en && wr_data[B_ECCLR]) |=> ec_clr_pulse);
endmodule

// File: tb/sim_can_ctl_ts.sv
module sim_can_ctl_ts;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        bit_tick = 1'b0;
    logic        ec_clr_ack = 1'b0;
    logic [15:0] rd_data, ts_value;
    logic        can_reset, loopback_en, basic_en, ec_clr_pulse;

    int n_chk = 0, n_bad = 0, cyc = 0;
    bit started = 0;

    // reference model state
    int m_ra, m_rb, m_lb, m_bc, m_sel, m_tsreq, m_ec, m_ph, m_ts;

    always #10 clk = ~clk;

    can_ctl_ts u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .bit_tick(bit_tick), .ec_clr_ack(ec_clr_ack),
        .can_reset(can_reset), .loopback_en(loopback_en), .basic_en(basic_en),
        .ec_clr_pulse(ec_clr_pulse), .ts_value(ts_value)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic int m_rd();
        return m_ra | (m_lb << 1) | (m_bc << 3) | (m_rb << 4) | (m_sel << 8)
             | (m_tsreq << 10) | ((m_ec != 0 ? 1 : 0) << 11);
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_ra = 1; m_rb = 1; m_lb = 0; m_bc = 0; m_sel = 0;
            m_tsreq = 0; m_ec = 0; m_ph = 0; m_ts = 0;
            started = 1;
        end else begin
            automatic int nd = wr_data;
            automatic bit chg = wr_en && (((nd >> 8) & 3) != m_sel);
            automatic bit adv = 0;
            automatic int ec_n = m_ec;
            if (m_tsreq || chg) m_ph = 0;
            else if (bit_tick) begin
                if (m_ph == m_sel) begin m_ph = 0; adv = 1; end
                else m_ph = m_ph + 1;
            end
            if (m_tsreq) m_ts = 0;
            else if (adv) m_ts = (m_ts + 1) & 16'hFFFF;
            m_tsreq = (wr_en && nd[10]) ? 1 : 0;
            case (m_ec)
                0: if (wr_en && nd[11]) ec_n = 1;
                1: ec_n = ec_clr_ack ? 0 : 2;
                default: if (ec_clr_ack) ec_n = 0;
            endcase
            m_ec = ec_n;
            if (wr_en) begin
                m_ra = nd[0]; m_lb = nd[1]; m_bc = nd[3]; m_rb = nd[4];
                m_sel = (nd >> 8) & 3;
            end
        end
    end

    always @(negedge clk) begin
        if (started) begin
            chk("R2 rd_data", rd_data, m_rd());
            chk("R4 ts_value", ts_value, m_ts);
            chk("R8 ec_clr_pulse", ec_clr_pulse, m_ec == 1);
            chk("R3 can_reset", can_reset, (m_ra | m_rb) != 0);
            chk("R3 loopback_en", loopback_en, m_lb);
            chk("R3 basic_en", basic_en, m_bc);
        end
    end

    task automatic step(input bit we, input int d, input bit tk, input bit ak);
        @(negedge clk);
        wr_en = we; wr_data = 16'(d); bit_tick = tk; ec_clr_ack = ak;
    endtask

    task automatic idle(input int n, input bit tk);
        for (int i = 0; i < n; i++) step(0, 0, tk, 0);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        #5000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 rd_data", rd_data, 16'h0011);
        chk("R1 ts_value", ts_value, 0);
        chk("R1 can_reset", can_reset, 1);
        // R2 leave reset, static fields, reserved bits read 0
        step(1, 16'h0000, 0, 0);
        step(1, 16'h000A, 0, 0);
        step(1, 16'hF0E4 | 16'h001B, 0, 0);
        step(0, 0, 0, 0);
        chk("R2 reserved read 0", rd_data & 16'hF0E4, 0);
        // R3 mismatched reset bits
        step(1, 16'h0001, 0, 0);
        step(0, 0, 0, 0);
        chk("R3 can_reset mismatch", can_reset, 1);
        step(1, 16'h0010, 0, 0);
        step(1, 16'h0000, 0, 0);
        // R4 each divide ratio, ticks every cycle and every other cycle
        for (int s = 0; s < 4; s++) begin
            step(1, s << 8, 0, 0);
            idle(20, 1);
            for (int k = 0; k < 10; k++) begin
                step(0, s << 8, 1, 0);
                step(0, 0, 0, 0);
            end
        end
        // R9 select change with a tick in the same cycle
        step(1, 16'h0200, 1, 0);
        idle(3, 1);
        step(1, 16'h0100, 1, 0);
        idle(5, 1);
        // R6 timestamp clear while increments are due
        step(1, 16'h0000, 1, 0);
        idle(6, 1);
        step(1, 16'h0400, 1, 0);
        step(0, 0, 1, 0);
        chk("R6 bit10 set", rd_data[10], 1);
        step(0, 0, 1, 0);
        chk("R6 ts cleared", ts_value, 0);
        chk("R6 bit10 self-clear", rd_data[10], 0);
        idle(4, 1);
        // R7 writing 0 to bit10/bit11 has no effect
        step(1, 16'h0800, 0, 0);
        idle(2, 0);
        step(1, 16'h0000, 0, 0);
        step(0, 0, 0, 0);
        chk("R7 bit11 still set", rd_data[11], 1);
        // R8 acknowledge releases
        step(0, 0, 0, 1);
        step(0, 0, 0, 0);
        chk("R8 bit11 cleared", rd_data[11], 0);
        // R8 ack in pulse cycle, ack while idle
        step(1, 16'h0800, 0, 0);
        step(0, 0, 0, 1);
        chk("R8 pulse", ec_clr_pulse, 1);
        step(0, 0, 0, 1);
        chk("R8 ack in pulse cycle", rd_data[11], 0);
        idle(3, 0);
        // R5 wrap
        step(1, 16'h0000, 1, 0);
        idle(65540, 1);
        chk("R5 wrapped low", ts_value < 16'h0010, 1);
        idle(4, 0);
        finish_run();
    end
endmodule